// File: doc/BRIEF.md
# Quadrature Position Counter

This block turns a pair of quadrature signals into a 16-bit position. It compares each input sample with the sample from the previous cycle. A single-channel transition counts one step when its polarity is allowed by the edge-mode setting. The phase relation between the two channels decides whether that step goes up or down. The position wraps in the range from zero to a programmable top value, so the block can follow a rotary shaft or a linear scale in either direction for any length of time.

Two sticky status bits record reversals of motion. One bit sets when counting turns from upward to downward, and the other sets on the opposite turn. Each bit sets only on the first step in the new direction. A write strobe with a one-hot or multi-hot data word clears the selected bits. A matching enable vector routes each bit onto a single interrupt line.

Both channel inputs are assumed to be already synchronous to `clk`. The block has no bus interface, no input filter and no prescaler.

Top module: `qenc_pos_counter`

## Requirements
- R1: After reset, the position is 0, every status bit is 0, the interrupt is low, and the recorded direction is upward (`dir_down_o` = 0).
- R2: When channel A leads channel B (A/B sequence 00, 10, 11, 01), each counted edge adds one to the position. When B leads A, each counted edge subtracts one. The new position appears after the clock edge that samples the changed input.
- R3: `edge_sel` selects the edges that are counted on both channels. 2'b00 counts rising edges only. 2'b01 counts falling edges only. 2'b10 counts both. 2'b11 counts nothing. An edge whose polarity is not selected leaves the position unchanged.
- R4: An upward step taken when the position equals the top value wraps the position to 0. An upward step taken when the position is above the top value (after the top value was lowered) also gives 0.
- R5: A downward step taken at position 0 loads the top value.
- R6: While `enc_en` is 0, no edge changes the position. Edges seen while disabled are not counted when `enc_en` returns to 1.
- R7: A cycle in which both channels change at once is treated as invalid, and the position does not change.
- R8: Status bit 6 sets on the first downward step after upward motion. Status bit 5 sets on the first upward step after downward motion. Further steps in the same direction do not set the bit again.
- R9: A cycle with `clr_wr` = 1 clears each status bit whose `clr_data` bit is 1. Bits written with 0 are unaffected. When a set and a clear hit the same bit in the same cycle, the set wins.
- R10: `irq_o` is the OR of (`flags_o` AND `irq_en`). Status bits other than 6 and 5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_en | input | 1 | Enables quadrature counting |
| edge_sel | input | 2 | Edge mode: 00 rising, 01 falling, 10 both, 11 none |
| chan_a | input | 1 | Quadrature channel A, synchronous |
| chan_b | input | 1 | Quadrature channel B, synchronous |
| reload_val | input | 16 | Top value of the position range |
| clr_wr | input | 1 | Strobe that applies `clr_data` as a clear mask |
| clr_data | input | 7 | Write-one-to-clear mask for the status bits |
| irq_en | input | 7 | Per-bit routing of status bits to the interrupt |
| count_o | output | 16 | Current position |
| dir_down_o | output | 1 | Direction of the last counted step (1 = downward) |
| flags_o | output | 7 | Sticky status bits: bit 6 up-to-down, bit 5 down-to-up |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that at most one step is issued per cycle and that the position holds when no step is issued or counting is disabled. They also check that both wrap points land on the right value, that a simultaneous change on both channels never produces a step, and that a reversal raises its status bit, which then stays set until it is cleared. Only the bench scenarios can show that the phase order of the channels gives the right direction in each edge mode, and that re-enabling counting does not count stale edges. The same holds for lowering the top value below the current position, the set-over-clear priority, and the gating of each status bit onto the interrupt.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_mode_e;

  // True when an edge that ends at level lvl is counted in mode m.
  function automatic logic edge_counted(edge_mode_e m, logic lvl);
    case (m)
      EDGE_RISE: return lvl;
      EDGE_FALL: return !lvl;
      EDGE_BOTH: return 1'b1;
      default:   return 1'b0;
    endcase
  endfunction

  // Direction of a single-channel move, given the new levels.
  // A leading B: A moves to differ from B, B moves to match A.
  function automatic logic step_is_up(logic moved_a, logic a, logic b);
    return moved_a ? (a != b) : (a == b);
  endfunction

endpackage

// File: rtl/qenc_edge_decode.sv
module qenc_edge_decode
  import qenc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enc_en,
  input  logic [1:0] edge_sel,
  input  logic       chan_a,
  input  logic       chan_b,
  output logic       step_up,
  output logic       step_dn
);

  logic prev_a, prev_b, primed;
  logic moved_a, moved_b, single_move, qualifies, go_up;
  edge_mode_e mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_a <= 1'b0;
      prev_b <= 1'b0;
      primed <= 1'b0;
    end else begin
      prev_a <= chan_a;
      prev_b <= chan_b;
      primed <= 1'b1;
    end
  end

  always_comb begin
    mode        = edge_mode_e'(edge_sel);
    moved_a     = chan_a ^ prev_a;
    moved_b     = chan_b ^ prev_b;
    single_move = moved_a ^ moved_b;
    qualifies   = primed && enc_en && single_move &&
                  edge_counted(mode, moved_a ? chan_a : chan_b);
    go_up       = step_is_up(moved_a, chan_a, chan_b);
    step_up     = qualifies && go_up;
    step_dn     = qualifies && !go_up;
  end

  // R7: a two-channel jump never yields a step
  p_no_double_move_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (moved_a && moved_b) |-> !(step_up || step_dn));

endmodule

// File: rtl/qenc_wrap_counter.sv
module qenc_wrap_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count
);

  function automatic logic [CNT_W-1:0] inc_wrap(logic [CNT_W-1:0] c, logic [CNT_W-1:0] top);
    return (c >= top) ? '0 : c + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] dec_wrap(logic [CNT_W-1:0] c, logic [CNT_W-1:0] top);
    return (c == '0) ? top : c - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (step_up) count <= inc_wrap(count, reload);
    else if (step_dn) count <= dec_wrap(count, reload);
  end

  // R2: the decoder never issues both directions in one cycle
  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_up, step_dn}));

  // R4: upward step at or above the top lands on zero
  p_wrap_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && count >= reload) |=> (count == '0));

  // R5: downward step at zero lands on the top value
  p_wrap_dn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && count == '0) |=> (count == $past(reload)));

  // R6: no step, no movement
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up || step_dn) |=> $stable(count));

endmodule

// File: rtl/qenc_dir_flags.sv
module qenc_dir_flags #(
  parameter int FLAG_W = 7,
  parameter int DN_BIT = 6,
  parameter int UP_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_up,
  input  logic              step_dn,
  input  logic              clr_wr,
  input  logic [FLAG_W-1:0] clr_data,
  input  logic [FLAG_W-1:0] irq_en,
  output logic [FLAG_W-1:0] flags,
  output logic              dir_dn,
  output logic              irq
);

  logic [FLAG_W-1:0] set_vec, clr_vec;

  always_comb begin
    set_vec         = '0;
    set_vec[DN_BIT] = step_dn && !dir_dn;
    set_vec[UP_BIT] = step_up && dir_dn;
    clr_vec         = clr_wr ? clr_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags  <= '0;
      dir_dn <= 1'b0;
    end else begin
      flags <= (flags & ~clr_vec) | set_vec;
      if (step_dn)      dir_dn <= 1'b1;
      else if (step_up) dir_dn <= 1'b0;
    end
  end

  assign irq = |(flags & irq_en);

  // R8: a turn from upward to downward raises the down bit
  p_dn_turn_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !dir_dn) |=> flags[DN_BIT]);

  // R8: a turn from downward to upward raises the up bit
  p_up_turn_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && dir_dn) |=> flags[UP_BIT]);

  // R9: a set bit stays until a clear selects it
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[DN_BIT] && !(clr_wr && clr_data[DN_BIT])) |=> flags[DN_BIT]);

endmodule

// File: rtl/qenc_pos_counter.sv
module qenc_pos_counter #(
  parameter int CNT_W  = 16,
  parameter int FLAG_W = 7,
  parameter int DN_BIT = 6,
  parameter int UP_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_en,
  input  logic [1:0]        edge_sel,
  input  logic              chan_a,
  input  logic              chan_b,
  input  logic [CNT_W-1:0]  reload_val,
  input  logic              clr_wr,
  input  logic [FLAG_W-1:0] clr_data,
  input  logic [FLAG_W-1:0] irq_en,
  output logic [CNT_W-1:0]  count_o,
  output logic              dir_down_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o
);

  logic step_up, step_dn;

  qenc_edge_decode u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .enc_en   (enc_en),
    .edge_sel (edge_sel),
    .chan_a   (chan_a),
    .chan_b   (chan_b),
    .step_up  (step_up),
    .step_dn  (step_dn)
  );

  qenc_wrap_counter #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_up (step_up),
    .step_dn (step_dn),
    .reload  (reload_val),
    .count   (count_o)
  );

  qenc_dir_flags #(.FLAG_W(FLAG_W), .DN_BIT(DN_BIT), .UP_BIT(UP_BIT)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_up  (step_up),
    .step_dn  (step_dn),
    .clr_wr   (clr_wr),
    .clr_data (clr_data),
    .irq_en   (irq_en),
    .flags    (flags_o),
    .dir_dn   (dir_down_o),
    .irq      (irq_o)
  );

  // R6: disabled counting keeps the position still
  p_idle_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_en |=> $stable(count_o));

endmodule

// File: tb/sim_qenc_pos_counter.sv
module sim_qenc_pos_counter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_en = 1'b0;
  logic [1:0]  edge_sel = 2'b10;
  logic        chan_a = 1'b0;
  logic        chan_b = 1'b0;
  logic [15:0] reload_val = 16'd9;
  logic        clr_wr = 1'b0;
  logic [6:0]  clr_data = '0;
  logic [6:0]  irq_en = '0;
  logic [15:0] count_o;
  logic        dir_down_o;
  logic [6:0]  flags_o;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  int exp_cnt = 0;
  int top = 9;
  int idx = 0;

  always #5 clk = ~clk;

  qenc_pos_counter u0 (.*);

  // Rows: {edge_sel, a, b, expected position}; top value 9.
  localparam logic [19:0] VEC [15] = '{
    {2'b10, 1'b1, 1'b0, 16'd1}, {2'b10, 1'b1, 1'b1, 16'd2},
    {2'b10, 1'b0, 1'b1, 16'd3}, {2'b10, 1'b0, 1'b0, 16'd4},
    {2'b10, 1'b0, 1'b1, 16'd3}, {2'b10, 1'b1, 1'b1, 16'd2},
    {2'b10, 1'b1, 1'b0, 16'd1}, {2'b10, 1'b0, 1'b0, 16'd0},
    {2'b10, 1'b0, 1'b1, 16'd9}, {2'b00, 1'b1, 1'b1, 16'd8},
    {2'b00, 1'b1, 1'b0, 16'd8}, {2'b00, 1'b0, 1'b0, 16'd8},
    {2'b00, 1'b0, 1'b1, 16'd7}, {2'b01, 1'b1, 1'b1, 16'd7},
    {2'b01, 1'b1, 1'b0, 16'd6}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Phase order for A leading B: 00,10,11,01.
  function automatic logic [1:0] phase(int i);
    case (i)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  task automatic drive_phase();
    {chan_a, chan_b} = phase(idx);
  endtask

  task automatic move(bit up, bit counted);
    idx = up ? (idx + 1) % 4 : (idx + 3) % 4;
    drive_phase();
    tick();
    if (counted) begin
      if (up) exp_cnt = (exp_cnt + 1 > top) ? 0 : exp_cnt + 1;
      else    exp_cnt = (exp_cnt == 0) ? top : exp_cnt - 1;
    end
  endtask

  task automatic clear(logic [6:0] m);
    clr_wr = 1'b1;
    clr_data = m;
    tick();
    clr_wr = 1'b0;
    clr_data = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    rst_n = 1'b1;
    enc_en = 1'b1;
    tick();
    chk("R1 position", count_o, 0);
    chk("R1 flags", flags_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 direction", dir_down_o, 0);

    // Table walk: R2 direction, R3 edge modes, R5 wrap at zero
    for (int i = 0; i < 15; i++) begin
      {edge_sel, chan_a, chan_b} = VEC[i][19:16];
      tick();
      chk($sformatf("R2/R3/R5 row %0d", i), count_o, VEC[i][15:0]);
    end
    edge_sel = 2'b11;               // R3: mode 11 counts nothing
    {chan_a, chan_b} = 2'b00;
    tick();
    chk("R3 mode none", count_o, 6);
    {chan_a, chan_b} = 2'b10;
    tick();
    chk("R3 mode none", count_o, 6);

    edge_sel = 2'b10;
    exp_cnt = 6;
    idx = 1;
    move(0, 1);
    chk("R2 down both", count_o, exp_cnt);

    // R4: up wrap at the top value
    clear(7'h7F);
    while (exp_cnt != top) move(1, 1);
    chk("R4 at top", count_o, top);
    move(1, 1);
    chk("R4 wrap to zero", count_o, 0);

    // R4: top lowered below position
    repeat (7) move(1, 1);
    chk("R4 before lower", count_o, 7);
    reload_val = 16'd3;
    top = 3;
    move(1, 1);
    chk("R4 above top wraps", count_o, 0);
    move(0, 1);
    chk("R5 down from zero", count_o, 3);
    reload_val = 16'd9;
    top = 9;

    // R6: disabled counting
    enc_en = 1'b0;
    repeat (3) move(1, 0);
    chk("R6 disabled", count_o, exp_cnt);
    enc_en = 1'b1;
    tick();
    chk("R6 re-enable no stale", count_o, exp_cnt);
    move(1, 1);
    chk("R6 counts again", count_o, exp_cnt);

    // R7: both channels at once
    idx = (idx + 2) % 4;
    drive_phase();
    tick();
    chk("R7 double move", count_o, exp_cnt);

    // R8/R9/R10: direction status bits
    move(1, 1);
    clear(7'h7F);
    chk("R9 clear all", flags_o, 0);
    move(0, 1);
    chk("R8 up-to-down bit", flags_o, 7'h40);
    chk("R8 direction", dir_down_o, 1);
    chk("R10 irq masked", irq_o, 0);
    irq_en = 7'h20;
    tick();
    chk("R10 other enable", irq_o, 0);
    irq_en = 7'h40;
    tick();
    chk("R10 irq on", irq_o, 1);
    clear(7'h00);
    chk("R9 zero mask", flags_o, 7'h40);
    clear(7'h20);
    chk("R9 other bit", flags_o, 7'h40);
    clear(7'h40);
    chk("R9 cleared", flags_o, 0);
    chk("R10 irq off", irq_o, 0);
    move(0, 1);
    chk("R8 no re-set", flags_o, 0);
    move(1, 1);
    chk("R8 down-to-up bit", flags_o, 7'h20);
    move(1, 1);
    chk("R8 up stays", flags_o, 7'h20);
    clr_wr = 1'b1;
    clr_data = 7'h40;
    move(0, 1);
    clr_wr = 1'b0;
    clr_data = '0;
    chk("R9 set wins", flags_o, 7'h60);
    chk("R10 unused bits", flags_o & 7'h1F, 0);
    chk("R2 final position", count_o, exp_cnt);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule